// File: doc/BRIEF.md
# Secondary Bus Grant Arbiter with Idle Parking

This block decides which of four external masters may start the next transaction on a shared secondary bus. Requests and grants at the pins are active low. When nobody is asking, the arbiter parks the bus on the bridge's own internal agent. That agent then drives the address/data, byte-enable and parity lines so they never float.

A grant decision is taken only while the bus is idle, which means the frame and ready-from-initiator lines are both high. Masters are served in round-robin order. The search starts at the master after the one most recently granted. Whenever ownership moves from one holder to another (external or parking), every grant is first held off for a fixed gap of clocks.

A synchronous bus-reset input removes every grant at once and requests zeros on the shared lines. An asynchronous active-low reset, released in step with the clock, puts the arbiter into its initial state.

Top module: `sec_bus_arbiter`

## Requirements
- R1: In every clock at most one grant is active, counting the four external grants and the parking grant.
- R2: Once any grant (external or parking) turns off, no grant turns on for at least GAP clocks (default 2).
- R3: While the bus is busy (frame_n or irdy_n low), the grant register holds its value.
- R4: When the bus is idle and a gap is not running, the winner is the first requesting master at or above index last+1, wrapping modulo 4. Here "last" is the master most recently granted, and after reset the search begins at master 0. A new winner takes over only after the gap. A grant is active when its gnt_n bit is 0.
- R5: When the bus is idle and no master requests, the parking grant (park_gnt=1) is issued. park_drive is 1 exactly while park_gnt is 1 and the bus is idle.
- R6: A request line held high (inactive, as an unused pin reads) never receives a grant.
- R7: While sec_reset is 1, all gnt_n bits are 1, park_gnt and park_drive are 0, and drive_zero is 1, in the same cycle. After release, the gap of R2 still applies.
- R8: While rst_n is 0, all gnt_n bits are 1, park_gnt is 0 and drive_zero is 1.
- R9: If the current holder is still the round-robin winner at an idle decision, its grant stays on with no gap. This covers a lone requester, and parking with no requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sec_reset | input | 1 | Synchronous bus reset, active high |
| req_n | input | 4 | Master requests, active low, bit i = master i |
| frame_n | input | 1 | Bus frame line, active low |
| irdy_n | input | 1 | Initiator-ready line, active low |
| gnt_n | output | 4 | Master grants, active low, bit i = master i |
| park_gnt | output | 1 | Internal (parking) grant, active high |
| park_drive | output | 1 | Internal agent drives address/data, byte enables and parity |
| drive_zero | output | 1 | Zeros must be driven on the shared lines (reset active) |

## Verification
The bench targets the following corner cases, and states what a wrong design would do in each:
- **Handover from parking to a fresh request.** A design that skipped the off gap would show a grant rising right after another one fell.
- **Requests arriving in mid-transaction.** A design that arbitrated during a busy bus would pull the grant away from the running master.
- **All four requesting at once.** The grants must rotate strictly. A wrong round-robin start point would let one master starve or skip a neighbour.
- **Reset and unused lines.** A bus reset asserted while a grant is held, and a permanently high request line, reveal grants that leak through reset or go to an idle pin.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Owner classification of the current grant register
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_EXT  = 2'd1,
    OWN_PARK = 2'd2
  } owner_e;
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N  = 4,
  parameter int PW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] last,
  output logic          any,
  output logic [PW-1:0] win
);
  // Search starts one above the last granted index and wraps around.
  always_comb begin
    any = 1'b0;
    win = last;
    for (int off = 1; off <= N; off++) begin
      int idx;
      idx = (int'(last) + off) % N;
      if (!any && req[idx]) begin
        any = 1'b1;
        win = PW'(idx);
      end
    end
  end
endmodule

// File: rtl/arb_gap_timer.sv
module arb_gap_timer #(
  parameter int GAP = 2,
  parameter int GW  = $clog2(GAP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam logic [GW-1:0] LOAD = GW'(GAP - 1);

  logic [GW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (start) begin
      cnt_d  = LOAD;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R2: the counter never runs past its load value
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD);
endmodule

// File: rtl/sec_bus_arbiter.sv
module sec_bus_arbiter #(
  parameter int NUM_REQ = 4,
  parameter int GAP     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_reset,
  input  logic [NUM_REQ-1:0] req_n,
  input  logic               frame_n,
  input  logic               irdy_n,
  output logic [NUM_REQ-1:0] gnt_n,
  output logic               park_gnt,
  output logic               park_drive,
  output logic               drive_zero
);
  import arb_pkg::*;

  localparam int PW    = $clog2(NUM_REQ);
  localparam int SLOTS = NUM_REQ + 1;
  localparam int PARK  = NUM_REQ;
  localparam logic [PW-1:0] LAST_INIT = PW'(NUM_REQ - 1);

  logic [SLOTS-1:0]   gnt_q, gnt_d, want;
  logic [PW-1:0]      last_q, last_d, win;
  logic [NUM_REQ-1:0] req_act;
  logic               any, bus_idle, gap_start, gap_busy;
  logic               gnt_en, last_en;
  owner_e             owner;

  assign req_act  = ~req_n;
  assign bus_idle = frame_n & irdy_n;

  arb_rr_pick #(.N(NUM_REQ), .PW(PW)) u_pick (
    .req  (req_act),
    .last (last_q),
    .any  (any),
    .win  (win)
  );

  arb_gap_timer #(.GAP(GAP)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .start (gap_start),
    .busy  (gap_busy)
  );

  always_comb begin
    if (gnt_q == '0)     owner = OWN_NONE;
    else if (gnt_q[PARK]) owner = OWN_PARK;
    else                  owner = OWN_EXT;
  end

  always_comb begin
    want = '0;
    if (any) want[win]  = 1'b1;
    else     want[PARK] = 1'b1;
  end

  // Next-state: reset > gap > busy hold > idle decision
  always_comb begin
    gnt_d     = gnt_q;
    last_d    = last_q;
    gap_start = 1'b0;
    if (sec_reset) begin
      gnt_d     = '0;
      gap_start = 1'b1;
    end else if (gap_busy) begin
      gnt_d = '0;
    end else if (bus_idle) begin
      if (owner == OWN_NONE || gnt_q == want) begin
        gnt_d = want;
        if (any) last_d = win;
      end else begin
        gnt_d     = '0;
        gap_start = 1'b1;
      end
    end
  end

  assign gnt_en  = (gnt_d != gnt_q);
  assign last_en = (last_d != last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gnt_q <= '0;
    else if (gnt_en) gnt_q <= gnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= LAST_INIT;
    else if (last_en) last_q <= last_d;
  end

  assign gnt_n      = ~(gnt_q[NUM_REQ-1:0] & {NUM_REQ{~sec_reset}});
  assign park_gnt   = gnt_q[PARK] & ~sec_reset;
  assign park_drive = park_gnt & bus_idle;
  assign drive_zero = sec_reset | ~rst_n;

  // R1: single owner at a time
  a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));

  // R2: a grant falling is followed by at least one more empty cycle
  if (GAP >= 2) begin : g_gap_chk
    a_r2_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(|gnt_q) |=> (gnt_q == '0));
  end

  // R3: no change while the bus is busy
  a_r3_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_idle && !sec_reset && !gap_busy) |=> $stable(gnt_q));

  // R5: parking is only taken with no request pending
  a_r5_park_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_q[PARK]) |-> $past(req_n == '1));

  // R6: a grant only rises for a requesting master
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_req_chk
    a_r6_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnt_q[i]) |-> $past(!req_n[i]));
  end

  // R7: bus reset empties the grant register
  a_r7_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sec_reset |=> (gnt_q == '0));
endmodule

// File: tb/test_sec_bus_arbiter.sv
module test_sec_bus_arbiter;
  localparam int N   = 4;
  localparam int GAP = 2;

  logic         clk;
  logic         rst_n, sec_reset, frame_n, irdy_n;
  logic [N-1:0] req_n;
  logic [N-1:0] gnt_n;
  logic         park_gnt, park_drive, drive_zero;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  // reference model state: -1 none, 0..N-1 external, N parking
  int m_gnt, m_gap, m_last;
  // gap monitor state
  int  off_cnt;
  bit  had_grant, prev_on;

  sec_bus_arbiter #(.NUM_REQ(N), .GAP(GAP)) i_sec_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .sec_reset(sec_reset), .req_n(req_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .gnt_n(gnt_n),
    .park_gnt(park_gnt), .park_drive(park_drive), .drive_zero(drive_zero)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      finish_run();
    end
  end

  // Behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gnt = -1; m_gap = 0; m_last = N - 1;
    end else if (sec_reset) begin
      m_gnt = -1; m_gap = GAP - 1;
    end else if (m_gap > 0) begin
      m_gnt = -1; m_gap--;
    end else if (frame_n && irdy_n) begin
      int w;
      w = N;
      for (int k = 1; k <= N; k++) begin
        int j;
        j = (m_last + k) % N;
        if (w == N && !req_n[j]) w = j;
      end
      if (m_gnt == -1 || m_gnt == w) begin
        if (w < N) m_last = w;
        m_gnt = w;
      end else begin
        m_gnt = -1; m_gap = GAP - 1;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic check_all();
    logic [N-1:0] e_gnt;
    logic e_park;
    int   on;
    bit   now_on;
    e_gnt  = '1;
    if (m_gnt >= 0 && m_gnt < N && !sec_reset) e_gnt[m_gnt] = 1'b0;
    e_park = (m_gnt == N) && !sec_reset;
    chk("R4 grant vs model", 32'(gnt_n), 32'(e_gnt));
    chk("R5 park grant vs model", 32'(park_gnt), 32'(e_park));
    chk("R5 park drive vs model", 32'(park_drive), 32'(e_park & frame_n & irdy_n));
    chk("R7 drive_zero", 32'(drive_zero), 32'(sec_reset | !rst_n));
    on = 0;
    for (int i = 0; i < N; i++) if (!gnt_n[i]) on++;
    if (park_gnt) on++;
    chk("R1 at most one grant", 32'(on <= 1), 32'd1);
    now_on = (on != 0);
    if (now_on && !prev_on && had_grant)
      chk("R2 off gap length", 32'(off_cnt >= GAP), 32'd1);
    if (now_on) begin had_grant = 1'b1; off_cnt = 0; end
    else off_cnt++;
    prev_on = now_on;
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
  endtask

  function automatic int grant_idx(logic [N-1:0] g);
    int r;
    r = -1;
    for (int i = 0; i < N; i++) if (!g[i]) r = i;
    return r;
  endfunction

  initial begin
    int prev, k, hits, got, trans;
    logic [N-1:0] held;
    off_cnt = 0; had_grant = 1'b0; prev_on = 1'b0;
    rst_n = 1'b0; sec_reset = 1'b0; req_n = '1; frame_n = 1'b1; irdy_n = 1'b1;
    @(negedge clk); @(negedge clk);
    // R8 reset state
    chk("R8 gnt_n in reset", 32'(gnt_n), 32'hF);
    chk("R8 park_gnt in reset", 32'(park_gnt), 32'd0);
    chk("R8 drive_zero in reset", 32'(drive_zero), 32'd1);
    rst_n = 1'b1;
    step();
    // R5 idle, no requests -> parking
    chk("R5 parked after reset", 32'(park_gnt), 32'd1);
    chk("R5 park drives idle bus", 32'(park_drive), 32'd1);

    // R4/R2 handover from park to master 0: off, gap, grant on third edge
    req_n = 4'b1110;
    step(); step();
    chk("R2 still off in gap", 32'(gnt_n), 32'hF);
    step();
    chk("R4 master 0 granted", 32'(gnt_n), 32'hE);

    // R3 busy bus holds the grant while others request
    frame_n = 1'b0; req_n = 4'b1000;
    for (int i = 0; i < 6; i++) begin
      step();
      chk("R3 grant held while busy", 32'(gnt_n), 32'hE);
    end
    frame_n = 1'b1; req_n = 4'b1001;
    step(); step(); step();
    chk("R4 next after 0 is 1", 32'(gnt_n), 32'hD);

    // R4 strict rotation with all requesting
    req_n = 4'b0000; prev = 1; trans = 0; held = gnt_n;
    for (int i = 0; i < 60; i++) begin
      step();
      if (gnt_n != 4'hF && gnt_n != held) begin
        k = grant_idx(gnt_n);
        chk("R4 rotation order", 32'(k), 32'((prev + 1) % N));
        prev = k; trans++;
      end
      held = gnt_n;
    end
    chk("R4 rotation progressed", 32'(trans >= 8), 32'd1);

    // R6 an inactive (high) request line is never granted
    req_n = 4'b0100; hits = 0; got = 0;
    for (int i = 0; i < 60; i++) begin
      step();
      if (!gnt_n[2]) hits++;
      if (gnt_n != 4'hF) got++;
    end
    chk("R6 idle line never granted", 32'(hits), 32'd0);
    chk("R6 others still served", 32'(got > 0), 32'd1);

    // R9 lone requester keeps its grant without a gap
    req_n = 4'b1101;
    for (int i = 0; i < 10 && gnt_n != 4'hD; i++) step();
    chk("R9 lone requester granted", 32'(gnt_n), 32'hD);
    for (int i = 0; i < 8; i++) begin
      step();
      chk("R9 grant kept", 32'(gnt_n), 32'hD);
    end

    // R7 bus reset while a grant is held: same-cycle removal
    sec_reset = 1'b1;
    #1;
    chk("R7 grants off at once", 32'(gnt_n), 32'hF);
    chk("R7 drive_zero on", 32'(drive_zero), 32'd1);
    chk("R7 park_drive off", 32'(park_drive), 32'd0);
    step();
    chk("R7 grants off during reset", 32'(gnt_n), 32'hF);
    sec_reset = 1'b0;
    step();
    chk("R7 gap after reset", 32'(gnt_n), 32'hF);
    step();
    chk("R7 regrant after gap", 32'(gnt_n), 32'hD);

    // R5 requests withdrawn: parking returns
    req_n = 4'hF;
    for (int i = 0; i < 6; i++) step();
    chk("R5 parked again", 32'(park_gnt), 32'd1);
    frame_n = 1'b0;
    step();
    chk("R5 no drive while busy", 32'(park_drive), 32'd0);
    frame_n = 1'b1;

    // Random traffic compared every clock against the model
    for (int i = 0; i < 2000; i++) begin
      req_n     = N'($urandom);
      frame_n   = ($urandom % 4) != 0;
      irdy_n    = ($urandom % 3) != 0;
      sec_reset = ($urandom % 64) == 0;
      step();
    end
    sec_reset = 1'b0;
    step();

    finish_run();
  end
endmodule